// File: doc/BRIEF.md
# Block Frame Circular Allocator

This block is the global control logic that hands out the frames of a tiled processor's instruction window to whole instruction blocks. A frame holds one in-flight block. The allocator grants a frame to each block the fetch unit wants to start. It records when the block's completion arrives and issues commit commands strictly in program order. When the commit acknowledgement returns, it puts the frame back into the free pool. If an exception or branch misprediction is reported for a block, the allocator flushes that block together with every younger block of the same thread, and it rewinds that thread's allocation point.

The frames form a circular buffer. The operating mode is captured while reset is held. In single-thread mode, thread 0 owns all frames as one ring. In multi-thread mode, the frames are split into equal rings of two frames each, and thread t owns frames 2t and 2t+1. Each thread keeps its own oldest and youngest pointers. Block fetch is paced: after a grant, no further grant is given until a fixed gap of cycles has passed. Grant, commit and flush outputs are combinational responses to the current inputs and the stored state, so they are valid in the same cycle. The state changes at the next clock edge.

Frame states are FREE, BUSY (fetching or executing), DONE (completion reported) and CMT (commit sent, waiting for the acknowledgement).

Top module: `block_frame_alloc`

## Requirements
- R1: While reset is high and after it falls, every frame is FREE. commit_vld and flush_vld are 0. The first grant for thread t goes to frame 0 in single-thread mode, or to frame 2t in multi-thread mode.
- R2: In single-thread mode, only fetch_tid 0 can be granted. Thread 0's frames are granted in ascending circular order 0,1,...,7,0. A granted frame is always FREE.
- R3: In multi-thread mode, thread t (0..3) is granted only frames 2t and 2t+1, alternating in circular order.
- R4: After a grant in cycle c, fetch_gnt stays 0 in cycles c+1 through c+7. A grant can be given again in cycle c+8.
- R5: A request is refused while the requesting thread already holds every frame of its ring (8 in single-thread mode, 2 in multi-thread mode). A frame counts as held until it is acknowledged or flushed.
- R6: A commit command (commit_vld=1, commit_frame) goes out only for a thread's oldest held frame, and only when that frame is DONE. At most one command is issued per cycle. Blocks of a thread commit in allocation order. In the cycle after the command, the frame is CMT.
- R7: When several threads have a committable oldest frame, the command goes to the first such thread after the previously served thread, in ascending circular order of thread number. After reset, thread 0 is checked first.
- R8: An acknowledgement frees a frame only if that frame is CMT, and the frame is FREE in the next cycle. An acknowledgement that names a frame in any other state is ignored.
- R9: An abort report for a BUSY or DONE frame raises flush_vld. flush_mask (bit i = frame i) marks that frame and every younger held frame of the same thread. Those frames become FREE, and the thread's next grant reuses the aborted frame.
- R10: An abort report that names a FREE or CMT frame is ignored: flush_vld stays 0 and no state changes.
- R11: A completion report for a frame that is not BUSY is ignored, and that frame cannot later be committed without its own completion.
- R12: In the cycle an abort is accepted, its thread gets neither a fetch grant nor a commit command.
- R13: The mode is taken from multi_mode only while rst is high. Changes to multi_mode after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is captured while high |
| multi_mode | input | 1 | 1 = four threads with two frames each, 0 = one thread with eight frames |
| fetch_req | input | 1 | Request to start a new block |
| fetch_tid | input | 2 | Thread of the request |
| fetch_gnt | output | 1 | Request granted this cycle |
| fetch_frame | output | 3 | Frame given to the new block |
| done_vld | input | 1 | Completion report valid |
| done_frame | input | 3 | Frame whose block completed |
| abort_vld | input | 1 | Exception or misprediction report valid |
| abort_frame | input | 3 | Frame of the offending block |
| commit_vld | output | 1 | Commit command valid |
| commit_frame | output | 3 | Frame to commit |
| ack_vld | input | 1 | Commit acknowledgement valid |
| ack_frame | input | 3 | Acknowledged frame |
| flush_vld | output | 1 | Flush command valid |
| flush_mask | output | 8 | Frames to flush, bit i = frame i |

## Verification
Some properties can be checked locally on every cycle, and the embedded assertions cover these. They check that a granted frame is free and that grants keep the fetch gap. They check that a thread never holds more than its ring. They check that a commit command leaves its frame waiting for the acknowledgement, and that an acknowledgement frees exactly that frame. They also check that the round-robin choice is always an eligible thread. Some behaviours need whole scenarios to show, and the bench's scenarios cover these: in-order commit after out-of-order completion, the exact frames a flush sweeps and the tail reuse that follows, ignored abort, completion and acknowledgement reports, same-cycle conflicts between abort and grant, and the mode being fixed at reset. Random traffic is compared against a frame-level model computed in the bench.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

    localparam int NUM_FRAMES     = 8;
    localparam int NUM_THREADS    = 4;
    localparam int FRAMES_PER_THR = NUM_FRAMES / NUM_THREADS;
    localparam int FID_W          = $clog2(NUM_FRAMES);
    localparam int TID_W          = $clog2(NUM_THREADS);
    localparam int CNT_W          = $clog2(NUM_FRAMES + 1);

    typedef logic [FID_W-1:0] fid_t;
    typedef logic [TID_W-1:0] tid_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        FR_FREE = 2'd0,
        FR_BUSY = 2'd1,
        FR_DONE = 2'd2,
        FR_CMT  = 2'd3
    } frame_st_e;

    typedef struct packed {
        fid_t head;
        fid_t tail;
        cnt_t cnt;
    } thr_ptr_t;

    // low index bits that wrap inside one thread's ring
    function automatic fid_t win_mask(input logic multi);
        return multi ? fid_t'(FRAMES_PER_THR - 1) : fid_t'(NUM_FRAMES - 1);
    endfunction

    function automatic fid_t wrap_next(input fid_t p, input logic multi);
        fid_t m;
        fid_t inc;
        m   = win_mask(multi);
        inc = fid_t'(p + fid_t'(1));
        return (p & ~m) | (inc & m);
    endfunction

    function automatic cnt_t ring_cap(input logic multi);
        return multi ? cnt_t'(FRAMES_PER_THR) : cnt_t'(NUM_FRAMES);
    endfunction

    function automatic tid_t thread_of(input fid_t g, input logic multi);
        return multi ? tid_t'(int'(g) / FRAMES_PER_THR) : '0;
    endfunction

    // age of frame g relative to the oldest frame of its ring
    function automatic cnt_t win_offset(input fid_t g, input fid_t head, input logic multi);
        fid_t d;
        d = fid_t'(g - head) & win_mask(multi);
        return cnt_t'(d);
    endfunction

endpackage

// File: rtl/bfa_fetch_pacer.sv
module bfa_fetch_pacer #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic ready
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);
    localparam logic [CW-1:0] GAP_V  = CW'(GAP);

    logic [CW-1:0] wait_q;

    assign ready = (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (grant) begin
            wait_q <= RELOAD;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - CW'(1);
        end
    end

    // independent distance counter for the checker
    logic [CW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= GAP_V;
        end else if (grant) begin
            since_q <= CW'(1);
        end else if (since_q != GAP_V) begin
            since_q <= since_q + CW'(1);
        end
    end

    // R4
    fetch_gap_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (since_q >= GAP_V));

endmodule

// File: rtl/bfa_thread_ctl.sv
module bfa_thread_ctl
    import bfa_pkg::*;
#(
    parameter int TID = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     multi,
    input  logic     grant,
    input  logic     ack,
    input  logic     abort,
    input  fid_t     abort_frame,
    input  cnt_t     abort_keep,
    output thr_ptr_t ptr_o,
    output logic     full_o
);
    localparam fid_t BASE = fid_t'(TID * FRAMES_PER_THR);

    thr_ptr_t q, d;

    always_comb begin
        d = q;
        if (ack) begin
            d.head = wrap_next(q.head, multi);
        end
        if (abort) begin
            d.tail = abort_frame;
            d.cnt  = abort_keep - cnt_t'(ack);
        end else begin
            if (grant) begin
                d.tail = wrap_next(q.tail, multi);
            end
            d.cnt = q.cnt + cnt_t'(grant) - cnt_t'(ack);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{head: BASE, tail: BASE, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign ptr_o  = q;
    assign full_o = (q.cnt >= ring_cap(multi));

    // R5
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= ring_cap(multi));

    // R8
    ack_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (q.cnt != '0));

endmodule

// File: rtl/bfa_commit_rr.sv
module bfa_commit_rr
    import bfa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] elig,
    output logic                   vld,
    output tid_t                   tid
);
    tid_t last_q;
    tid_t cand;

    always_comb begin
        vld  = 1'b0;
        tid  = last_q;
        cand = last_q;
        for (int i = 1; i <= NUM_THREADS; i++) begin
            cand = tid_t'((int'(last_q) + i) % NUM_THREADS);
            if (!vld && elig[cand]) begin
                vld = 1'b1;
                tid = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= tid_t'(NUM_THREADS - 1);
        end else if (vld) begin
            last_q <= tid;
        end
    end

    // R7
    pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> elig[tid]);

    // R6
    no_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> vld);

endmodule

// File: rtl/block_frame_alloc.sv
module block_frame_alloc
    import bfa_pkg::*;
#(
    parameter int FETCH_GAP = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  multi_mode,
    input  logic                  fetch_req,
    input  logic [TID_W-1:0]      fetch_tid,
    output logic                  fetch_gnt,
    output logic [FID_W-1:0]      fetch_frame,
    input  logic                  done_vld,
    input  logic [FID_W-1:0]      done_frame,
    input  logic                  abort_vld,
    input  logic [FID_W-1:0]      abort_frame,
    output logic                  commit_vld,
    output logic [FID_W-1:0]      commit_frame,
    input  logic                  ack_vld,
    input  logic [FID_W-1:0]      ack_frame,
    output logic                  flush_vld,
    output logic [NUM_FRAMES-1:0] flush_mask
);
    logic      mode_q;
    frame_st_e st_q [NUM_FRAMES];
    frame_st_e st_d [NUM_FRAMES];

    thr_ptr_t               ptr    [NUM_THREADS];
    logic [NUM_THREADS-1:0] t_full;
    logic [NUM_THREADS-1:0] t_grant;
    logic [NUM_THREADS-1:0] t_ack;
    logic [NUM_THREADS-1:0] t_abort;
    logic [NUM_THREADS-1:0] t_elig;

    logic gap_ok;
    logic ab_ok;
    tid_t ab_tid;
    cnt_t ab_keep;
    logic ack_ok;
    tid_t ack_tid;
    tid_t cm_tid;

    // mode is fixed while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= multi_mode;
        end
    end

    // abort and acknowledge qualification
    assign ab_ok   = abort_vld && (st_q[abort_frame] == FR_BUSY || st_q[abort_frame] == FR_DONE);
    assign ab_tid  = thread_of(abort_frame, mode_q);
    assign ab_keep = win_offset(abort_frame, ptr[ab_tid].head, mode_q);
    assign ack_ok  = ack_vld && (st_q[ack_frame] == FR_CMT);
    assign ack_tid = thread_of(ack_frame, mode_q);

    // fetch grant
    assign fetch_gnt = fetch_req && gap_ok
                    && (mode_q || fetch_tid == '0)
                    && !t_full[fetch_tid]
                    && !(ab_ok && ab_tid == fetch_tid);
    assign fetch_frame = ptr[fetch_tid].tail;

    bfa_fetch_pacer #(
        .GAP(FETCH_GAP)
    ) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .grant(fetch_gnt),
        .ready(gap_ok)
    );

    // per-thread ring pointers
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign t_grant[t] = fetch_gnt && (fetch_tid == tid_t'(t));
        assign t_ack[t]   = ack_ok && (ack_tid == tid_t'(t));
        assign t_abort[t] = ab_ok && (ab_tid == tid_t'(t));
        assign t_elig[t]  = (ptr[t].cnt != '0)
                         && (st_q[ptr[t].head] == FR_DONE)
                         && !t_abort[t];

        bfa_thread_ctl #(
            .TID(t)
        ) u_thr (
            .clk        (clk),
            .rst        (rst),
            .multi      (mode_q),
            .grant      (t_grant[t]),
            .ack        (t_ack[t]),
            .abort      (t_abort[t]),
            .abort_frame(abort_frame),
            .abort_keep (ab_keep),
            .ptr_o      (ptr[t]),
            .full_o     (t_full[t])
        );
    end

    // in-order commit, round robin over threads
    bfa_commit_rr u_rr (
        .clk (clk),
        .rst (rst),
        .elig(t_elig),
        .vld (commit_vld),
        .tid (cm_tid)
    );
    assign commit_frame = ptr[cm_tid].head;

    // flush sweep: aborted frame and younger frames of its ring
    always_comb begin
        for (int g = 0; g < NUM_FRAMES; g++) begin
            flush_mask[g] = ab_ok
                && (thread_of(fid_t'(g), mode_q) == ab_tid)
                && (win_offset(fid_t'(g), ptr[ab_tid].head, mode_q) >= ab_keep)
                && (win_offset(fid_t'(g), ptr[ab_tid].head, mode_q) < ptr[ab_tid].cnt);
        end
    end
    assign flush_vld = ab_ok;

    // frame state machine
    always_comb begin
        for (int g = 0; g < NUM_FRAMES; g++) begin
            st_d[g] = st_q[g];
            if (flush_mask[g]) begin
                st_d[g] = FR_FREE;
            end else if (ack_ok && ack_frame == fid_t'(g)) begin
                st_d[g] = FR_FREE;
            end else if (commit_vld && commit_frame == fid_t'(g)) begin
                st_d[g] = FR_CMT;
            end else if (done_vld && done_frame == fid_t'(g) && st_q[g] == FR_BUSY) begin
                st_d[g] = FR_DONE;
            end else if (fetch_gnt && fetch_frame == fid_t'(g)) begin
                st_d[g] = FR_BUSY;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < NUM_FRAMES; g++) begin
            if (rst) begin
                st_q[g] <= FR_FREE;
            end else begin
                st_q[g] <= st_d[g];
            end
        end
    end

    // R2
    gnt_free_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_gnt |-> (st_q[fetch_frame] == FR_FREE));

    // R6
    commit_mark_chk: assert property (@(posedge clk) disable iff (rst)
        commit_vld |=> (st_q[$past(commit_frame)] == FR_CMT));

    // R8
    ack_free_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && st_q[ack_frame] == FR_CMT) |=> (st_q[$past(ack_frame)] == FR_FREE));

    // R9
    flush_self_chk: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> flush_mask[abort_frame]);

endmodule

// File: tb/block_frame_alloc_tb.sv
module block_frame_alloc_tb;
    import bfa_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       multi_mode;
    logic       fetch_req;
    logic [1:0] fetch_tid;
    logic       fetch_gnt;
    logic [2:0] fetch_frame;
    logic       done_vld;
    logic [2:0] done_frame;
    logic       abort_vld;
    logic [2:0] abort_frame;
    logic       commit_vld;
    logic [2:0] commit_frame;
    logic       ack_vld;
    logic [2:0] ack_frame;
    logic       flush_vld;
    logic [7:0] flush_mask;

    always #5 clk = ~clk;

    block_frame_alloc #(.FETCH_GAP(8)) u_dut (
        .clk(clk), .rst(rst), .multi_mode(multi_mode),
        .fetch_req(fetch_req), .fetch_tid(fetch_tid),
        .fetch_gnt(fetch_gnt), .fetch_frame(fetch_frame),
        .done_vld(done_vld), .done_frame(done_frame),
        .abort_vld(abort_vld), .abort_frame(abort_frame),
        .commit_vld(commit_vld), .commit_frame(commit_frame),
        .ack_vld(ack_vld), .ack_frame(ack_frame),
        .flush_vld(flush_vld), .flush_mask(flush_mask)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // bench model: 0 free, 1 busy, 2 done, 3 commit pending
    int mst [8];
    int mhd [4];
    int mtl [4];
    int mcn [4];
    int mgap;
    int mrr;
    bit mm;

    bit         e_gnt, e_cv, e_fv, ab_ok, ack_ok;
    int         e_ff, e_cf, at, aoff, ct, n_elig;
    logic [7:0] e_fm;
    string      gtag_ovr = "";
    string      ctag_ovr = "";
    string      ftag_ovr = "";

    function automatic int mthr(int g);
        return mm ? g / 2 : 0;
    endfunction

    function automatic int mnext(int p);
        return mm ? (p ^ 1) : ((p + 1) % 8);
    endfunction

    function automatic int moff(int g, int h);
        return mm ? ((g - h) & 1) : ((g - h) & 7);
    endfunction

    function automatic int pick_state(int s);
        int base;
        base = int'($urandom % 8);
        for (int k = 0; k < 8; k++) begin
            if (mst[(base + k) % 8] == s) return (base + k) % 8;
        end
        return base;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset(bit m);
        mm = m;
        for (int g = 0; g < 8; g++) mst[g] = 0;
        for (int t = 0; t < 4; t++) begin
            mhd[t] = 2 * t;
            mtl[t] = 2 * t;
            mcn[t] = 0;
        end
        mgap = 0;
        mrr  = 3;
    endtask

    task automatic predict();
        int cap;
        cap   = mm ? 2 : 8;
        ab_ok = abort_vld && (mst[abort_frame] == 1 || mst[abort_frame] == 2);
        at    = mthr(int'(abort_frame));
        aoff  = moff(int'(abort_frame), mhd[at]);
        e_fm  = '0;
        if (ab_ok) begin
            for (int g = 0; g < 8; g++) begin
                if (mthr(g) == at && moff(g, mhd[at]) >= aoff && moff(g, mhd[at]) < mcn[at])
                    e_fm[g] = 1'b1;
            end
        end
        e_fv  = ab_ok;
        e_gnt = fetch_req && mgap == 0 && (mm || fetch_tid == 0)
             && mcn[fetch_tid] < cap && !(ab_ok && at == int'(fetch_tid));
        e_ff  = mtl[fetch_tid];
        e_cv  = 1'b0;
        ct    = 0;
        n_elig = 0;
        for (int i = 1; i <= 4; i++) begin
            int c;
            c = (mrr + i) % 4;
            if (mcn[c] > 0 && mst[mhd[c]] == 2 && !(ab_ok && at == c)) begin
                n_elig++;
                if (!e_cv) begin
                    e_cv = 1'b1;
                    ct   = c;
                end
            end
        end
        e_cf   = mhd[ct];
        ack_ok = ack_vld && mst[ack_frame] == 3;
    endtask

    task automatic model_update();
        for (int g = 0; g < 8; g++) begin
            if (e_fm[g]) mst[g] = 0;
            else if (ack_ok && g == int'(ack_frame)) mst[g] = 0;
            else if (e_cv && g == e_cf) mst[g] = 3;
            else if (done_vld && g == int'(done_frame) && mst[g] == 1) mst[g] = 2;
            else if (e_gnt && g == e_ff) mst[g] = 1;
        end
        for (int t = 0; t < 4; t++) begin
            bit a, gr, ab;
            a  = ack_ok && mthr(int'(ack_frame)) == t;
            gr = e_gnt && int'(fetch_tid) == t;
            ab = ab_ok && at == t;
            if (ab) begin
                mcn[t] = aoff - int'(a);
                mtl[t] = int'(abort_frame);
            end else begin
                mcn[t] = mcn[t] + int'(gr) - int'(a);
                if (gr) mtl[t] = mnext(mtl[t]);
            end
            if (a) mhd[t] = mnext(mhd[t]);
        end
        if (e_gnt) mgap = 7;
        else if (mgap > 0) mgap--;
        if (e_cv) mrr = ct;
    endtask

    // called at a falling edge with inputs already driven
    task automatic step();
        string gt, cg, ft;
        #1;
        predict();
        if (gtag_ovr != "") gt = gtag_ovr;
        else if (ab_ok && at == int'(fetch_tid) && fetch_req) gt = "R12";
        else if (mgap > 0) gt = "R4";
        else if (!mm && fetch_tid != 0) gt = "R2";
        else if (mcn[fetch_tid] >= (mm ? 2 : 8)) gt = "R5";
        else gt = mm ? "R3" : "R2";
        if (ctag_ovr != "") cg = ctag_ovr;
        else cg = (n_elig > 1) ? "R7" : "R6";
        if (ftag_ovr != "") ft = ftag_ovr;
        else ft = (abort_vld && !ab_ok) ? "R10" : "R9";
        chk(gt, "fetch_gnt", int'(fetch_gnt), int'(e_gnt));
        if (e_gnt) chk(gt, "fetch_frame", int'(fetch_frame), e_ff);
        chk(cg, "commit_vld", int'(commit_vld), int'(e_cv));
        if (e_cv) chk(cg, "commit_frame", int'(commit_frame), e_cf);
        chk(ft, "flush_vld", int'(flush_vld), int'(e_fv));
        chk(ft, "flush_mask", int'(flush_mask), int'(e_fm));
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        fetch_req = 0; fetch_tid = 0;
        done_vld = 0; done_frame = 0;
        abort_vld = 0; abort_frame = 0;
        ack_vld = 0; ack_frame = 0;
    endtask

    task automatic do_reset(bit m);
        rst = 1'b1;
        multi_mode = m;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while reset is held
        chk("R1", "commit_vld in reset", int'(commit_vld), 0);
        chk("R1", "flush_vld in reset", int'(flush_vld), 0);
        rst = 1'b0;
        model_reset(m);
    endtask

    task automatic random_cycle();
        fetch_req = ($urandom % 2) == 0;
        if (mm) fetch_tid = 2'($urandom % 4);
        else    fetch_tid = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0;
        done_vld   = ($urandom % 3) == 0;
        done_frame = 3'((($urandom % 4) != 0) ? pick_state(1) : int'($urandom % 8));
        abort_vld   = ($urandom % 24) == 0;
        abort_frame = 3'((($urandom % 2) != 0) ? pick_state(1) : int'($urandom % 8));
        ack_vld   = ($urandom % 3) == 0;
        ack_frame = 3'((($urandom % 4) != 0) ? pick_state(3) : int'($urandom % 8));
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, run did not finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1;
        multi_mode = 1'b0;
        idle_inputs();

        // single-thread mode, directed
        do_reset(1'b0);
        gtag_ovr = "R1"; ctag_ovr = "R1"; ftag_ovr = "R1";
        step();
        fetch_req = 1; fetch_tid = 0;
        step();                       // R1: first grant is frame 0
        gtag_ovr = ""; ctag_ovr = ""; ftag_ovr = "";
        repeat (75) step();           // R4 pacing, R2 order, R5 refusal once full
        fetch_tid = 2;
        step();                       // R2: other threads refused
        fetch_req = 0;
        done_vld = 1; done_frame = 3; step();
        done_frame = 0; step();       // R6: frame 3 done but frame 0 oldest
        done_vld = 0; step();
        ctag_ovr = "R8";
        ack_vld = 1; ack_frame = 2; step();   // R8: ack on busy frame ignored
        ack_vld = 0; step();
        ack_vld = 1; ack_frame = 0; step();
        ack_vld = 0; step();
        ctag_ovr = "";
        abort_vld = 1; abort_frame = 5; step();  // R9: sweeps 5,6,7
        abort_frame = 6; step();                 // R10: now free
        abort_frame = 0; step();                 // R10: freed frame
        abort_vld = 0;
        fetch_req = 1; fetch_tid = 0;
        repeat (20) step();           // R9: regrant starts at frame 5
        fetch_req = 0;
        repeat (3) step();

        // R11: completion on a free frame is dropped
        do_reset(1'b0);
        done_vld = 1; done_frame = 0; step();
        done_vld = 0; fetch_req = 1; fetch_tid = 0; step();
        fetch_req = 0;
        ctag_ovr = "R11";
        repeat (4) step();
        ctag_ovr = "";

        repeat (4000) random_cycle();

        // multi-thread mode
        do_reset(1'b1);
        idle_inputs();
        multi_mode = 1'b0;
        gtag_ovr = "R13";
        fetch_req = 1; fetch_tid = 2; step();    // R13: still multi, frame 4
        gtag_ovr = "";
        repeat (8) step();
        fetch_tid = 1;
        repeat (8) step();            // thread 1 gets frame 2
        fetch_req = 0;
        repeat (8) step();
        fetch_req = 1; fetch_tid = 1;
        abort_vld = 1; abort_frame = 2;
        gtag_ovr = "R12";
        step();                       // R12: abort blocks same-thread grant
        gtag_ovr = "";
        abort_vld = 0;
        step();                       // R9: regrant of frame 2
        fetch_req = 0;
        for (int t = 0; t < 4; t++) begin
            fetch_req = 1; fetch_tid = 2'(t);
            repeat (8) step();
        end
        fetch_req = 0;
        for (int g = 0; g < 8; g++) begin
            done_vld = 1; done_frame = 3'(g);
            step();                   // R7: several threads ready together
        end
        done_vld = 0;
        repeat (6) step();

        for (int i = 0; i < 6000; i++) begin
            multi_mode = 1'($urandom % 2);
            random_cycle();
        end

        idle_inputs();
        repeat (2) step();
        summary();
        $finish;
    end

endmodule